// File: doc/BRIEF.md
# Variable-Width SPI Master Engine

This block is a serial peripheral interface master that takes its work from a small transmit queue and returns what it captures through a receive queue. Every transmit word names its own shift length, from 0 to 24 bits. Software, or the logic around the block, writes words through one of two write strobes. The strobe chosen decides whether the chip-select lines stay low after that chunk, which lets several chunks run as one framed transaction. After every chunk the engine holds the serial clock idle for two full periods. When a chunk ends a frame, chip select rises one serial clock period after the last bit.

The serial clock runs at the system clock divided by 2×(divider+1). Clock polarity, the launch edge and the sample edge are separate controls. The block reports queue levels, full and empty flags, a busy flag and the remaining bit count. It has two level interrupt outputs, each with its own enable. The engine starts a chunk only when the receive queue has room for its result, so received words are never lost.

Top module: `vwspi_master`

## Requirements
- R1: After reset all chip-select lines are high, `sck` equals `cfg_cpol`, both queues are empty with level 0, `busy` is low, and no interrupt is raised.
- R2: Each half period of `sck` lasts `cfg_div`+1 system clocks, so rising edges within a chunk are 2×(`cfg_div`+1) clocks apart.
- R3: A transmit word carries the bit count in bits 31:24 and left-justified data in bits 23:0. The engine gives exactly that many `sck` pulses, clamped to 24, and sends bit 23 first. `bit_cnt` shows the bits remaining in the current chunk and never exceeds 24.
- R4: Received bits are shifted in MSB first. The chunk's result is pushed right-aligned in the low bits, with all higher bits zero.
- R5: A word written with `tx_wr_hold` keeps chip select low after its chunk, including while the engine waits for more data. A word written with `tx_wr_rel` lets chip select rise after its chunk. `sck` only toggles while chip select is low.
- R6: Between chunks `sck` stays idle for two full periods. In a held frame the next chunk's first edge comes 5×(`cfg_div`+1) clocks after the previous chunk's last edge.
- R7: At the end of a frame chip select rises 2×(`cfg_div`+1) clocks after the last `sck` edge.
- R8: `sck` rests at `cfg_cpol` outside a chunk. `cfg_launch_rise` and `cfg_sample_rise` pick the edges on which `mosi` changes and `miso` is captured.
- R9: Each queue holds 4 words. A write to a full transmit queue is dropped. Reading an empty receive queue gives zero.
- R10: The engine does not start a chunk while the receive queue is full. It resumes once a word is read.
- R11: A one-cycle `cfg_clear` empties both queues.
- R12: `irq_txe` is high when `irq_txe_en` is set and the transmit queue is empty. `irq_idle` is high when `irq_idle_en` is set, the transmit queue is empty and the engine is not busy. Chip select is high whenever `irq_idle` is raised.
- R13: All `NCS` chip-select lines assert and release together. `busy` is high from the start of a chunk until the engine returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Engine enable; low forces the engine idle |
| cfg_div | input | DIV_W | Half-period divider (0 = fastest) |
| cfg_cpol | input | 1 | Idle level of `sck` |
| cfg_launch_rise | input | 1 | 1: `mosi` changes on rising `sck` |
| cfg_sample_rise | input | 1 | 1: `miso` captured on rising `sck` |
| cfg_clear | input | 1 | Empties both queues |
| irq_txe_en | input | 1 | Enable for the transmit-empty interrupt |
| irq_idle_en | input | 1 | Enable for the idle interrupt |
| tx_data | input | 32 | Transmit word: count in 31:24, data in 23:0 |
| tx_wr_hold | input | 1 | Write strobe; chip select held after the chunk |
| tx_wr_rel | input | 1 | Write strobe; chip select released after the chunk |
| rx_rd | input | 1 | Pops the receive queue head |
| rx_data | output | 32 | Receive queue head, zero when empty |
| tx_level | output | LVL_W | Transmit queue fill level |
| rx_level | output | LVL_W | Receive queue fill level |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| busy | output | 1 | Engine active or holding a frame |
| bit_cnt | output | 6 | Bits left in the current chunk |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low chip selects |
| irq_txe | output | 1 | Transmit-empty interrupt |
| irq_idle | output | 1 | Idle interrupt |

## Verification
A wrong pulse count or a misaligned shift register shows up in the first receive word, because the bench loops `mosi` back to `miso` and compares each word with the value predicted from its count and payload. A broken gap or frame counter moves edge-to-edge distances and the chip-select release cycle by whole half periods; the bench measures these in system clocks for the chunk that caused them. A wrong hold attribute or a lost receive-space gate changes how often chip select rises, or the levels reported, by the end of that same short transaction.

// File: rtl/vwspi_pkg.sv
package vwspi_pkg;

    localparam int WORD_W = 32;
    localparam int DATA_W = 24;
    localparam int LEN_W  = 8;

    // Transmit queue entry: frame attribute plus the written word
    typedef struct packed {
        logic              keep_cs;
        logic [LEN_W-1:0]  nbits;
        logic [DATA_W-1:0] payload;
    } tx_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2,
        ST_HOLD  = 2'd3
    } eng_state_t;

endpackage

// File: rtl/vwspi_fifo.sv
module vwspi_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr_i,
    input  logic                          push_i,
    input  logic [W-1:0]                  din_i,
    input  logic                          pop_i,
    output logic [W-1:0]                  dout_o,
    output logic [$clog2(DEPTH+1)-1:0]    count_o,
    output logic                          full_o,
    output logic                          empty_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fptr_t;

    fptr_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full_o  = (q.cnt == CW'(DEPTH));
    assign empty_o = (q.cnt == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign dout_o  = empty_o ? '0 : mem[q.rp];
    assign count_o = q.cnt;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d = q;
        if (clr_i) begin
            d = '0;
        end else begin
            if (do_push) d.wp = nxt(q.wp);
            if (do_pop)  d.rp = nxt(q.rp);
            case ({do_push, do_pop})
                2'b10:   d.cnt = q.cnt + 1'b1;
                2'b01:   d.cnt = q.cnt - 1'b1;
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr_i) mem[q.wp] <= din_i;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i && !clr_i) |=> (full_o && count_o == CW'(DEPTH))); // R9
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> empty_o); // R11
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CW'(DEPTH)); // R9

endmodule

// File: rtl/vwspi_engine.sv
module vwspi_engine
    import vwspi_pkg::*;
#(
    parameter int DIV_W         = 12,
    parameter int CNT_W         = 6,
    parameter int MAX_BITS      = 24,
    parameter int GAP_HALVES    = 4,
    parameter int CS_OFF_HALVES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              cpol_i,
    input  logic              launch_rise_i,
    input  logic              sample_rise_i,
    input  logic              tx_avail_i,
    input  tx_entry_t         tx_entry_i,
    output logic              tx_pop_o,
    input  logic              rx_room_i,
    output logic              rx_push_o,
    output logic [WORD_W-1:0] rx_word_o,
    input  logic              miso_i,
    output logic              sck_o,
    output logic              mosi_o,
    output logic              cs_act_o,
    output logic              busy_o,
    output logic [CNT_W-1:0]  bit_cnt_o
);
    localparam int GAP_W = $clog2(GAP_HALVES + 1);

    typedef struct packed {
        eng_state_t        state;
        logic [DIV_W-1:0]  div_cnt;
        logic              half;
        logic              first;
        logic              sck_act;
        logic              cs_act;
        logic              keep;
        logic [CNT_W-1:0]  bits;
        logic [GAP_W-1:0]  gap;
        logic [DATA_W-1:0] tx_sh;
        logic [DATA_W-1:0] rx_sh;
    } eng_t;

    eng_t q, d;
    logic tick, start_ok, lead_rise, sample_lead, launch_lead;
    logic [DATA_W-1:0] rx_nx;

    assign tick        = (q.div_cnt == div_i);
    assign start_ok    = enable_i && tx_avail_i && rx_room_i;
    assign lead_rise   = ~cpol_i;
    assign sample_lead = (sample_rise_i == lead_rise);
    assign launch_lead = (launch_rise_i == lead_rise);
    assign rx_nx       = {q.rx_sh[DATA_W-2:0], miso_i};

    function automatic eng_t load(input eng_t cur, input tx_entry_t e);
        eng_t r;
        r         = cur;
        r.state   = ST_SHIFT;
        r.div_cnt = '0;
        r.half    = 1'b0;
        r.first   = 1'b1;
        r.sck_act = 1'b0;
        r.cs_act  = 1'b1;
        r.keep    = e.keep_cs;
        r.bits    = (e.nbits > LEN_W'(MAX_BITS)) ? CNT_W'(MAX_BITS) : CNT_W'(e.nbits);
        r.gap     = '0;
        r.tx_sh   = e.payload;
        r.rx_sh   = '0;
        return r;
    endfunction

    always_comb begin
        d         = q;
        tx_pop_o  = 1'b0;
        rx_push_o = 1'b0;
        rx_word_o = '0;
        if (q.state == ST_SHIFT || q.state == ST_GAP)
            d.div_cnt = tick ? '0 : q.div_cnt + 1'b1;
        case (q.state)
            ST_IDLE, ST_HOLD: begin
                if (start_ok) begin
                    d        = load(q, tx_entry_i);
                    tx_pop_o = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (q.bits == '0) begin
                    rx_push_o = 1'b1;
                    d.state   = ST_GAP;
                    d.gap     = '0;
                    d.div_cnt = '0;
                end else if (tick) begin
                    if (!q.half) begin
                        d.half    = 1'b1;
                        d.sck_act = 1'b1;
                        if (sample_lead) d.rx_sh = rx_nx;
                        if (launch_lead && !q.first) d.tx_sh = q.tx_sh << 1;
                    end else begin
                        d.half    = 1'b0;
                        d.sck_act = 1'b0;
                        d.first   = 1'b0;
                        d.bits    = q.bits - 1'b1;
                        if (!sample_lead) d.rx_sh = rx_nx;
                        if (!launch_lead) d.tx_sh = q.tx_sh << 1;
                        if (q.bits == CNT_W'(1)) begin
                            rx_push_o = 1'b1;
                            rx_word_o = WORD_W'(sample_lead ? q.rx_sh : rx_nx);
                            d.state   = ST_GAP;
                            d.gap     = '0;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    d.gap = q.gap + 1'b1;
                    if (q.gap == GAP_W'(CS_OFF_HALVES - 1) && !q.keep)
                        d.cs_act = 1'b0;
                    if (q.gap == GAP_W'(GAP_HALVES - 1)) begin
                        if (!q.keep) begin
                            d.state = ST_IDLE;
                        end else if (start_ok) begin
                            d        = load(q, tx_entry_i);
                            tx_pop_o = 1'b1;
                        end else begin
                            d.state = ST_HOLD;
                        end
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
        if (!enable_i) begin
            d.state   = ST_IDLE;
            d.cs_act  = 1'b0;
            d.sck_act = 1'b0;
            d.div_cnt = '0;
            tx_pop_o  = 1'b0;
            rx_push_o = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck_o     = cpol_i ^ q.sck_act;
    assign mosi_o    = q.tx_sh[DATA_W-1];
    assign cs_act_o  = q.cs_act;
    assign busy_o    = (q.state != ST_IDLE);
    assign bit_cnt_o = (q.state == ST_SHIFT) ? q.bits : '0;

    AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != ST_SHIFT) |-> (sck_o == cpol_i)); // R8
    AST_BITS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt_o <= CNT_W'(MAX_BITS)); // R3
    AST_SCK_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        q.sck_act |-> cs_act_o); // R5
    AST_IDLE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !cs_act_o); // R13

endmodule

// File: rtl/vwspi_master.sv
module vwspi_master
    import vwspi_pkg::*;
#(
    parameter int NCS        = 3,
    parameter int FIFO_DEPTH = 4,
    parameter int DIV_W      = 12,
    parameter int LVL_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_cpol,
    input  logic              cfg_launch_rise,
    input  logic              cfg_sample_rise,
    input  logic              cfg_clear,
    input  logic              irq_txe_en,
    input  logic              irq_idle_en,
    input  logic [31:0]       tx_data,
    input  logic              tx_wr_hold,
    input  logic              tx_wr_rel,
    input  logic              rx_rd,
    output logic [31:0]       rx_data,
    output logic [LVL_W-1:0]  tx_level,
    output logic [LVL_W-1:0]  rx_level,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              busy,
    output logic [5:0]        bit_cnt,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NCS-1:0]    cs_n,
    output logic              irq_txe,
    output logic              irq_idle
);
    localparam int ENT_W = $bits(tx_entry_t);
    localparam int CW    = $clog2(FIFO_DEPTH + 1);

    tx_entry_t          tx_in, tx_head;
    logic [ENT_W-1:0]   tx_head_raw;
    logic [CW-1:0]      tx_cnt, rx_cnt;
    logic               tx_pop, rx_push, cs_act;
    logic [WORD_W-1:0]  rx_word;

    assign tx_in   = tx_entry_t'({tx_wr_hold, tx_data});
    assign tx_head = tx_entry_t'(tx_head_raw);

    vwspi_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cfg_clear),
        .push_i  (tx_wr_hold | tx_wr_rel),
        .din_i   (tx_in),
        .pop_i   (tx_pop),
        .dout_o  (tx_head_raw),
        .count_o (tx_cnt),
        .full_o  (tx_full),
        .empty_o (tx_empty)
    );

    vwspi_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cfg_clear),
        .push_i  (rx_push),
        .din_i   (rx_word),
        .pop_i   (rx_rd),
        .dout_o  (rx_data),
        .count_o (rx_cnt),
        .full_o  (rx_full),
        .empty_o (rx_empty)
    );

    vwspi_engine #(.DIV_W(DIV_W)) u_eng (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable_i      (cfg_enable),
        .div_i         (cfg_div),
        .cpol_i        (cfg_cpol),
        .launch_rise_i (cfg_launch_rise),
        .sample_rise_i (cfg_sample_rise),
        .tx_avail_i    (!tx_empty),
        .tx_entry_i    (tx_head),
        .tx_pop_o      (tx_pop),
        .rx_room_i     (!rx_full),
        .rx_push_o     (rx_push),
        .rx_word_o     (rx_word),
        .miso_i        (miso),
        .sck_o         (sck),
        .mosi_o        (mosi),
        .cs_act_o      (cs_act),
        .busy_o        (busy),
        .bit_cnt_o     (bit_cnt)
    );

    assign tx_level = LVL_W'(tx_cnt);
    assign rx_level = LVL_W'(rx_cnt);
    assign cs_n     = {NCS{~cs_act}};
    assign irq_txe  = irq_txe_en & tx_empty;
    assign irq_idle = irq_idle_en & tx_empty & ~busy;

    AST_RX_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full); // R10
    AST_IDLE_IRQ_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_idle |-> (&cs_n)); // R12
    AST_POP_HAS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> (busy && cs_n == '0)); // R13

endmodule

// File: tb/sim_vwspi_master.sv
module sim_vwspi_master;
    localparam int NCS = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [11:0] cfg_div = 12'd1;
    logic        cfg_cpol = 1'b0;
    logic        cfg_launch_rise = 1'b0;
    logic        cfg_sample_rise = 1'b1;
    logic        cfg_clear = 1'b0;
    logic        irq_txe_en = 1'b0;
    logic        irq_idle_en = 1'b0;
    logic [31:0] tx_data = '0;
    logic        tx_wr_hold = 1'b0;
    logic        tx_wr_rel = 1'b0;
    logic        rx_rd = 1'b0;
    logic [31:0] rx_data;
    logic [7:0]  tx_level, rx_level;
    logic        tx_full, tx_empty, rx_full, rx_empty, busy;
    logic [5:0]  bit_cnt;
    logic        sck, mosi, miso;
    logic [NCS-1:0] cs_n;
    logic        irq_txe, irq_idle;

    always #2 clk = ~clk;
    assign miso = mosi;

    vwspi_master u0 (.*);

    int errs = 0, checks = 0, cyc = 0;
    bit mon_en = 0;
    logic [31:0] expq[$];

    int rises, cs_rises, last_rise, last_fall, cs_rise_cyc, min_iv, max_iv;
    bit have_rise = 0, prev_sck = 0, prev_cs = 1, cs_split = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // edge recorder
    always @(negedge clk) begin
        if (cs_n != {NCS{cs_n[0]}}) cs_split = 1;
        if (sck && !prev_sck) begin
            if (have_rise && !cs_n[0]) begin
                if (cyc - last_rise < min_iv) min_iv = cyc - last_rise;
                if (cyc - last_rise > max_iv) max_iv = cyc - last_rise;
            end
            last_rise = cyc;
            have_rise = 1;
            rises++;
        end
        if (!sck && prev_sck) last_fall = cyc;
        if (cs_n[0] && !prev_cs) begin
            cs_rise_cyc = cyc;
            cs_rises++;
        end
        if (cs_n[0]) have_rise = 0;
        prev_sck = sck;
        prev_cs  = cs_n[0];
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rx_rd) begin
            rx_rd = 1'b0;
        end else if (mon_en && !rx_empty) begin
            if (expq.size() == 0) begin
                check(0, "R4 unexpected receive word", rx_data, 32'h0);
            end else begin
                logic [31:0] e;
                e = expq.pop_front();
                check(rx_data == e, "R4 receive word", rx_data, e);
            end
            rx_rd = 1'b1;
        end
    end

    function automatic logic [31:0] exp_rx(input logic [7:0] n, input logic [23:0] p);
        int k;
        k = (n > 8'd24) ? 24 : int'(n);
        if (k == 0) return 32'h0;
        return 32'(p >> (24 - k));
    endfunction

    task automatic clear_meas();
        rises = 0; cs_rises = 0; min_iv = 1 << 30; max_iv = 0;
    endtask

    task automatic wr(input logic [7:0] n, input logic [23:0] p, input bit hold);
        @(negedge clk);
        tx_data = {n, p};
        if (hold) tx_wr_hold = 1'b1; else tx_wr_rel = 1'b1;
        @(negedge clk);
        tx_wr_hold = 1'b0;
        tx_wr_rel  = 1'b0;
    endtask

    task automatic send(input logic [7:0] n, input logic [23:0] p, input bit hold);
        expq.push_back(exp_rx(n, p));
        wr(n, p, hold);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
        while (!(!busy && tx_empty && (!mon_en || (rx_empty && expq.size() == 0))))
            @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk); cfg_clear = 1'b1;
        @(negedge clk); cfg_clear = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=hung expected=done");
        errs++; checks++;
        summary();
        $finish;
    end

    initial begin
        clear_meas();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cs_n == 3'b111, "R1 cs_n", 32'(cs_n), 32'h7);
        check(sck == 1'b0, "R1 sck", 32'(sck), 32'h0);
        check(tx_empty && rx_empty && tx_level == 0 && rx_level == 0, "R1 queues", {tx_level, rx_level}, 32'h0);
        check(!busy, "R1 busy", 32'(busy), 32'h0);
        check(!irq_txe && !irq_idle, "R1 irq", {irq_txe, irq_idle}, 32'h0);
        // R9 empty receive read gives zero
        check(rx_data == 32'h0, "R9 empty read", rx_data, 32'h0);

        cfg_enable = 1'b1; mon_en = 1;
        // single release chunk, div=1
        clear_meas();
        send(8'd8, 24'hA50000, 0);
        settle();
        check(rises == 8, "R3 pulse count 8", rises, 8);
        check(min_iv == 4 && max_iv == 4, "R2 period div1", max_iv, 4);
        check(cs_rise_cyc - last_fall == 4, "R7 cs release delay", cs_rise_cyc - last_fall, 4);
        check(cs_rises == 1, "R5 one frame", cs_rises, 1);

        // held frame of two chunks
        clear_meas();
        send(8'd16, 24'h123400, 1);
        send(8'd8, 24'h560000, 0);
        settle();
        check(rises == 24, "R3 pulse count held frame", rises, 24);
        check(cs_rises == 1, "R5 hold keeps cs low", cs_rises, 1);
        check(max_iv == 12, "R6 inter-chunk gap", max_iv, 12);
        check(min_iv == 4, "R2 period in frame", min_iv, 4);

        // two release chunks: two frames
        clear_meas();
        send(8'd8, 24'h3C0000, 0);
        send(8'd8, 24'hC30000, 0);
        settle();
        check(cs_rises == 2, "R5 release drops cs", cs_rises, 2);

        // held chunk with nothing behind it
        clear_meas();
        send(8'd4, 24'h900000, 1);
        repeat (100) @(negedge clk);
        check(cs_n == 3'b000 && busy, "R5 cs held while waiting", 32'(cs_n), 32'h0);
        send(8'd4, 24'h600000, 0);
        settle();
        check(cs_rises == 1 && rises == 8, "R5 held wait frame", cs_rises, 1);

        // full width and clamp
        clear_meas();
        send(8'd24, 24'hC3A55A, 0);
        settle();
        check(rises == 24, "R3 24-bit chunk", rises, 24);
        clear_meas();
        send(8'd31, 24'h0F0F0F, 0);
        settle();
        check(rises == 24, "R3 length clamp", rises, 24);
        clear_meas();
        send(8'd5, 24'hB80000, 0);
        settle();
        check(rises == 5, "R3 odd length", rises, 5);

        // slower divider
        cfg_div = 12'd3;
        clear_meas();
        send(8'd8, 24'h810000, 0);
        settle();
        check(min_iv == 8 && max_iv == 8, "R2 period div3", max_iv, 8);
        check(cs_rise_cyc - last_fall == 8, "R7 cs release div3", cs_rise_cyc - last_fall, 8);
        cfg_div = 12'd1;

        // inverted polarity, launch rising, sample falling
        @(negedge clk);
        cfg_cpol = 1'b1; cfg_launch_rise = 1'b1; cfg_sample_rise = 1'b0;
        @(negedge clk);
        check(sck == 1'b1, "R8 idle level cpol1", 32'(sck), 32'h1);
        clear_meas();
        send(8'd12, 24'hABC000, 0);
        settle();
        check(rises == 12 && sck == 1'b1, "R8 cpol1 transfer", rises, 12);
        @(negedge clk);
        cfg_cpol = 1'b0; cfg_launch_rise = 1'b0; cfg_sample_rise = 1'b1;

        // R9 drop on full, R10 stall on full receive queue
        mon_en = 0;
        cfg_enable = 1'b0;
        send(8'd8, 24'h110000, 0);
        send(8'd8, 24'h220000, 0);
        send(8'd8, 24'h330000, 0);
        send(8'd8, 24'h440000, 0);
        wr(8'd8, 24'h550000, 0);
        check(tx_level == 8'd4 && tx_full, "R9 drop when full", tx_level, 4);
        cfg_enable = 1'b1;
        settle();
        check(rx_level == 8'd4 && rx_full, "R9 four results", rx_level, 4);
        send(8'd8, 24'h660000, 0);
        repeat (200) @(negedge clk);
        check(tx_level == 8'd1 && rx_level == 8'd4, "R10 stall while rx full", tx_level, 1);
        check(cs_n == 3'b111 && !busy, "R10 no chunk started", 32'(cs_n), 32'h7);
        mon_en = 1;
        settle();
        check(expq.size() == 0 && rx_empty, "R10 resumed and drained", expq.size(), 0);

        // R11 clear
        cfg_enable = 1'b0;
        wr(8'd8, 24'h010000, 0);
        wr(8'd8, 24'h020000, 0);
        wr(8'd8, 24'h030000, 0);
        check(tx_level == 8'd3, "R11 tx loaded", tx_level, 3);
        pulse_clear();
        check(tx_empty && tx_level == 0, "R11 tx cleared", tx_level, 0);
        mon_en = 0;
        cfg_enable = 1'b1;
        wr(8'd8, 24'h770000, 0);
        settle();
        check(rx_level == 8'd1, "R11 rx loaded", rx_level, 1);
        pulse_clear();
        check(rx_empty && rx_level == 0 && rx_data == 0, "R11 rx cleared", rx_level, 0);
        mon_en = 1;

        // R12 interrupts, R13 busy and bit count
        irq_txe_en = 1'b1; irq_idle_en = 1'b1;
        @(negedge clk);
        check(irq_txe && irq_idle, "R12 idle irqs", {irq_txe, irq_idle}, 32'h3);
        send(8'd24, 24'h5A5A5A, 0);
        while (!busy) @(negedge clk);
        check(irq_txe && !irq_idle, "R12 irqs while busy", {irq_txe, irq_idle}, 32'h2);
        check(bit_cnt == 6'd24, "R13 bit count at start", bit_cnt, 24);
        settle();
        check(irq_idle && irq_txe, "R12 idle after frame", {irq_txe, irq_idle}, 32'h3);
        cfg_enable = 1'b0;
        wr(8'd8, 24'h990000, 0);
        check(!irq_txe && !irq_idle, "R12 pending entry masks irqs", {irq_txe, irq_idle}, 32'h0);
        pulse_clear();
        irq_txe_en = 1'b0; irq_idle_en = 1'b0;
        @(negedge clk);
        check(!irq_txe && !irq_idle, "R12 enables off", {irq_txe, irq_idle}, 32'h0);

        check(!cs_split, "R13 cs lines together", 32'(cs_split), 32'h0);
        check(expq.size() == 0, "R4 all results seen", expq.size(), 0);

        summary();
        $finish;
    end

endmodule